// File: doc/BRIEF.md
# Seconds Counter with Match Alarm

This peripheral keeps time as a free-running 32-bit count of seconds. The count advances on a one-cycle strobe that arrives once per second from a timebase outside the block. Software sets the time by writing a load value. It arms an alarm by writing a match value. A single interrupt line goes high when the count reaches the match value, provided the mask bit is set. Software clears the interrupt with a write-one-to-clear access.

All registers sit on a simple 32-bit register bus with select, write enable, a 12-bit byte address, write data and read data. Read data is combinational and valid in the cycle the select is asserted with write enable low. Writes take effect on the rising clock edge at which select and write enable are both high. Eight identification bytes sit at the top of the 4 KB window so that software can probe the block.

The block needs no sequencing of its own. Every effect completes at the clock edge of the access or tick that causes it, so the design has no state machine. Its state is four registers: count, match, load value and mask, plus the raw status flag.

Top module: `rtc_alarm_top`

## Requirements
- R1: After active-low reset the count, match, load value, mask and raw status are all 0. The interrupt output is low.
- R2: A write to offset 0x08 sets the count to the written value at that edge. A read of 0x08 returns the last value written there, and a read of 0x00 returns the current count.
- R3: Each tick strobe adds 1 to the count, and 0xFFFFFFFF wraps to 0. Without a tick or a load write, the count holds.
- R4: If a load write and a tick fall in the same cycle, the count takes the written value and the tick is dropped.
- R5: Raw status (bit 0 of offset 0x14) is set on the tick edge at which the count becomes equal to the match value. A match value below the count fires only after the count wraps.
- R6: A write to the match register (0x04) or to the load register (0x08) sets raw status at that same edge if, after the write, the count equals the match value.
- R7: Only bit 0 of the mask register (0x10) is stored, and its other bits read as 0. Both the masked status (bit 0 of 0x18) and the interrupt output equal raw status AND mask.
- R8: A write to 0x1C clears raw status when write-data bit 0 is 1, and a 0 in that bit leaves it unchanged. A read of 0x1C returns 0. A set and a clear in the same cycle leave raw status set.
- R9: Offset 0x0C reads as 1, and writes to it change nothing.
- R10: Reads of 0xFE0, 0xFE4 and so on up to 0xFFC return, in bits [7:0], the bytes 0x31, 0x10, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1 in that address order.
- R11: Writes to 0x00, 0x14, 0x18 or to unmapped offsets change no state. Reads of unmapped offsets return 0.
- R12: A read of 0x04 returns the stored match value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_tick | input | 1 | One-cycle strobe, once per second |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address in the 4 KB window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| alarm_irq | output | 1 | Level interrupt, raw status AND mask |

## Verification
Read data is combinational. The bench drives each read on the falling edge and samples bus_rdata a couple of nanoseconds later, before any rising edge. A write or a tick applied at one rising edge becomes visible in the register contents, in raw status and in alarm_irq right after that edge. The bench therefore releases the stimulus on the next falling edge and makes its check no earlier than that. The same-cycle cases (a load write with a tick, a clear with a tick that causes a match) are driven as one cycle, and the result is read back on the following cycle.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;
    localparam int ADDR_W = 12;

    // register offsets decoded by software drivers
    localparam logic [ADDR_W-1:0] OFF_COUNT = 12'h000;
    localparam logic [ADDR_W-1:0] OFF_MATCH = 12'h004;
    localparam logic [ADDR_W-1:0] OFF_LOAD  = 12'h008;
    localparam logic [ADDR_W-1:0] OFF_CTRL  = 12'h00C;
    localparam logic [ADDR_W-1:0] OFF_MASK  = 12'h010;
    localparam logic [ADDR_W-1:0] OFF_RAW   = 12'h014;
    localparam logic [ADDR_W-1:0] OFF_MSTAT = 12'h018;
    localparam logic [ADDR_W-1:0] OFF_CLEAR = 12'h01C;

    // identification bytes occupy the last 32 bytes of the window
    localparam logic [6:0] ID_WIN_TAG = 7'h7F;

    function automatic logic [7:0] id_byte(input logic [2:0] idx);
        logic [7:0] b;
        case (idx)
            3'd0:    b = 8'h31;
            3'd1:    b = 8'h10;
            3'd2:    b = 8'h14;
            3'd3:    b = 8'h00;
            3'd4:    b = 8'h0D;
            3'd5:    b = 8'hF0;
            3'd6:    b = 8'h05;
            default: b = 8'hB1;
        endcase
        return b;
    endfunction
endpackage

// File: rtl/rtc_sec_counter.sv
module rtc_sec_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         load_en,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] cnt_q,
    output logic [W-1:0] cnt_nxt
);
    localparam logic [W-1:0] ONE = W'(1);

    // a load beats a coincident tick
    always_comb begin
        if (load_en)
            cnt_nxt = load_val;
        else if (tick)
            cnt_nxt = cnt_q + ONE;
        else
            cnt_nxt = cnt_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_nxt;
    end
endmodule

// File: rtl/rtc_alarm_irq.sv
module rtc_alarm_irq #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         load_en,
    input  logic         match_en,
    input  logic         mask_en,
    input  logic         clr_en,
    input  logic [W-1:0] wdata,
    input  logic         wbit0,
    input  logic [W-1:0] cnt_nxt,
    output logic [W-1:0] match_q,
    output logic         mask_q,
    output logic         raw_q,
    output logic         irq
);
    logic [W-1:0] match_nxt;
    logic         eval;
    logic         hit;
    logic         raw_d;

    assign match_nxt = match_en ? wdata : match_q;
    // compare only when the count or the match value may change
    assign eval      = tick | load_en | match_en;
    assign hit       = eval && (cnt_nxt == match_nxt);

    always_comb begin
        if (hit)
            raw_d = 1'b1;
        else if (clr_en && wbit0)
            raw_d = 1'b0;
        else
            raw_d = raw_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            match_q <= '0;
            mask_q  <= 1'b0;
            raw_q   <= 1'b0;
        end else begin
            match_q <= match_nxt;
            raw_q   <= raw_d;
            if (mask_en)
                mask_q <= wbit0;
        end
    end

    assign irq = raw_q & mask_q;
endmodule

// File: rtl/rtc_id_rom.sv
module rtc_id_rom (
    input  logic [2:0] idx,
    output logic [7:0] byte_o
);
    import rtc_alarm_pkg::*;
    assign byte_o = id_byte(idx);
endmodule

// File: rtl/rtc_alarm_top.sv
module rtc_alarm_top #(
    parameter int DATA_W = 32
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              sec_tick,
    input  logic                              bus_sel,
    input  logic                              bus_wr,
    input  logic [rtc_alarm_pkg::ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]                 bus_wdata,
    output logic [DATA_W-1:0]                 bus_rdata,
    output logic                              alarm_irq
);
    import rtc_alarm_pkg::*;

    localparam int PAD_BIT  = DATA_W - 1;
    localparam int PAD_BYTE = DATA_W - 8;

    logic              wr_acc;
    logic              load_en, match_en, mask_en, clr_en;
    logic [DATA_W-1:0] cnt_q, cnt_nxt, match_q, lval_q;
    logic              mask_q, raw_q;
    logic [7:0]        id_val;
    logic              in_id_win;

    assign wr_acc   = bus_sel & bus_wr;
    assign load_en  = wr_acc && (bus_addr == OFF_LOAD);
    assign match_en = wr_acc && (bus_addr == OFF_MATCH);
    assign mask_en  = wr_acc && (bus_addr == OFF_MASK);
    assign clr_en   = wr_acc && (bus_addr == OFF_CLEAR);

    rtc_sec_counter #(.W(DATA_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (sec_tick),
        .load_en  (load_en),
        .load_val (bus_wdata),
        .cnt_q    (cnt_q),
        .cnt_nxt  (cnt_nxt)
    );

    rtc_alarm_irq #(.W(DATA_W)) u_alm (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (sec_tick),
        .load_en  (load_en),
        .match_en (match_en),
        .mask_en  (mask_en),
        .clr_en   (clr_en),
        .wdata    (bus_wdata),
        .wbit0    (bus_wdata[0]),
        .cnt_nxt  (cnt_nxt),
        .match_q  (match_q),
        .mask_q   (mask_q),
        .raw_q    (raw_q),
        .irq      (alarm_irq)
    );

    rtc_id_rom u_id (
        .idx    (bus_addr[4:2]),
        .byte_o (id_val)
    );

    // last value written to the load register, for readback
    always_ff @(posedge clk) begin
        if (!rst_n)
            lval_q <= '0;
        else if (load_en)
            lval_q <= bus_wdata;
    end

    assign in_id_win = (bus_addr[ADDR_W-1:5] == ID_WIN_TAG);

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            if (in_id_win) begin
                bus_rdata = {{PAD_BYTE{1'b0}}, id_val};
            end else begin
                case (bus_addr)
                    OFF_COUNT: bus_rdata = cnt_q;
                    OFF_MATCH: bus_rdata = match_q;
                    OFF_LOAD:  bus_rdata = lval_q;
                    OFF_CTRL:  bus_rdata = {{PAD_BIT{1'b0}}, 1'b1};
                    OFF_MASK:  bus_rdata = {{PAD_BIT{1'b0}}, mask_q};
                    OFF_RAW:   bus_rdata = {{PAD_BIT{1'b0}}, raw_q};
                    OFF_MSTAT: bus_rdata = {{PAD_BIT{1'b0}}, raw_q & mask_q};
                    default:   bus_rdata = '0;
                endcase
            end
        end
    end
endmodule

// File: rtl/rtc_alarm_chk.sv
module rtc_alarm_chk #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sec_tick,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [11:0]       bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              alarm_irq,
    input  logic [DATA_W-1:0] cnt_q,
    input  logic              raw_q
);
    logic ld_w, mt_w, mk_w, cl_w;
    assign ld_w = bus_sel && bus_wr && (bus_addr == 12'h008);
    assign mt_w = bus_sel && bus_wr && (bus_addr == 12'h004);
    assign mk_w = bus_sel && bus_wr && (bus_addr == 12'h010);
    assign cl_w = bus_sel && bus_wr && (bus_addr == 12'h01C);

    // R2
    load_sets_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_w |=> (cnt_q == $past(bus_wdata)));

    // R3
    tick_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick && !ld_w) |=> (cnt_q == $past(cnt_q) + 1'b1));

    // R3
    count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sec_tick && !ld_w) |=> $stable(cnt_q));

    // R6
    match_write_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mt_w && !sec_tick && (bus_wdata == cnt_q)) |=> raw_q);

    // R7
    mask_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mk_w && !bus_wdata[0]) |=> !alarm_irq);

    // R8
    clear_drops_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cl_w && bus_wdata[0] && !sec_tick) |=> !raw_q);

    // R9
    ctrl_reads_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && (bus_addr == 12'h00C)) |-> (bus_rdata == 1));
endmodule

bind rtc_alarm_top rtc_alarm_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sec_tick  (sec_tick),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .alarm_irq (alarm_irq),
    .cnt_q     (cnt_q),
    .raw_q     (raw_q)
);

// File: tb/sim_rtc_alarm_top.sv
module sim_rtc_alarm_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sec_tick = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        alarm_irq;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    rtc_alarm_top u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .sec_tick  (sec_tick),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .alarm_irq (alarm_irq)
    );

    // vector: [49:48] op (0 read-check, 1 write, 2 tick), [47:44] req, [43:32] addr, [31:0] data
    localparam int NV = 56;
    localparam logic [49:0] VEC [NV] = '{
        {2'd0, 4'd1,  12'h000, 32'h0},        // R1
        {2'd0, 4'd1,  12'h014, 32'h0},        // R1
        {2'd0, 4'd1,  12'h010, 32'h0},        // R1
        {2'd1, 4'd2,  12'h008, 32'h10},       // R2
        {2'd0, 4'd2,  12'h000, 32'h10},       // R2
        {2'd0, 4'd2,  12'h008, 32'h10},       // R2
        {2'd1, 4'd12, 12'h004, 32'h12},       // R12
        {2'd0, 4'd12, 12'h004, 32'h12},       // R12
        {2'd2, 4'd3,  12'h000, 32'h0},        // R3
        {2'd0, 4'd3,  12'h000, 32'h11},       // R3
        {2'd0, 4'd5,  12'h014, 32'h0},        // R5
        {2'd2, 4'd5,  12'h000, 32'h0},        // R5
        {2'd0, 4'd5,  12'h014, 32'h1},        // R5
        {2'd0, 4'd7,  12'h018, 32'h0},        // R7
        {2'd1, 4'd7,  12'h010, 32'hFFFFFFFF}, // R7
        {2'd0, 4'd7,  12'h010, 32'h1},        // R7
        {2'd0, 4'd7,  12'h018, 32'h1},        // R7
        {2'd1, 4'd8,  12'h01C, 32'hFFFFFFFE}, // R8
        {2'd0, 4'd8,  12'h014, 32'h1},        // R8
        {2'd1, 4'd8,  12'h01C, 32'h1},        // R8
        {2'd0, 4'd8,  12'h014, 32'h0},        // R8
        {2'd0, 4'd8,  12'h01C, 32'h0},        // R8
        {2'd1, 4'd9,  12'h00C, 32'h0},        // R9
        {2'd0, 4'd9,  12'h00C, 32'h1},        // R9
        {2'd1, 4'd11, 12'h000, 32'h5555},     // R11
        {2'd0, 4'd11, 12'h000, 32'h12},       // R11
        {2'd1, 4'd11, 12'h014, 32'h1},        // R11
        {2'd0, 4'd11, 12'h014, 32'h0},        // R11
        {2'd1, 4'd11, 12'h100, 32'hAB},       // R11
        {2'd0, 4'd11, 12'h100, 32'h0},        // R11
        {2'd0, 4'd11, 12'h004, 32'h12},       // R11
        {2'd1, 4'd3,  12'h008, 32'hFFFFFFFF}, // R3
        {2'd1, 4'd5,  12'h004, 32'h0},        // R5
        {2'd0, 4'd5,  12'h014, 32'h0},        // R5
        {2'd2, 4'd3,  12'h000, 32'h0},        // R3
        {2'd0, 4'd3,  12'h000, 32'h0},        // R3
        {2'd0, 4'd5,  12'h014, 32'h1},        // R5
        {2'd1, 4'd8,  12'h01C, 32'h1},        // R8
        {2'd0, 4'd6,  12'h014, 32'h0},        // R6
        {2'd1, 4'd6,  12'h004, 32'h0},        // R6
        {2'd0, 4'd6,  12'h014, 32'h1},        // R6
        {2'd1, 4'd6,  12'h01C, 32'h1},        // R6
        {2'd1, 4'd6,  12'h004, 32'h77},       // R6
        {2'd0, 4'd6,  12'h014, 32'h0},        // R6
        {2'd1, 4'd6,  12'h008, 32'h77},       // R6
        {2'd0, 4'd6,  12'h014, 32'h1},        // R6
        {2'd0, 4'd10, 12'hFE0, 32'h31},       // R10
        {2'd0, 4'd10, 12'hFE4, 32'h10},       // R10
        {2'd0, 4'd10, 12'hFE8, 32'h14},       // R10
        {2'd0, 4'd10, 12'hFEC, 32'h00},       // R10
        {2'd0, 4'd10, 12'hFF0, 32'h0D},       // R10
        {2'd0, 4'd10, 12'hFF4, 32'hF0},       // R10
        {2'd0, 4'd10, 12'hFF8, 32'h05},       // R10
        {2'd0, 4'd10, 12'hFFC, 32'hB1},       // R10
        {2'd0, 4'd11, 12'hFC0, 32'h0},        // R11
        {2'd1, 4'd8,  12'h01C, 32'h1}         // R8
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_check(input string req, input logic [11:0] a, input logic [31:0] exp);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #2;
        check(req, bus_rdata, exp);
        bus_sel = 1'b0;
    endtask

    task automatic one_tick();
        @(negedge clk);
        sec_tick = 1'b1;
        @(negedge clk);
        sec_tick = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            string tag;
            tag = $sformatf("R%0d vec%0d", VEC[i][47:44], i);
            case (VEC[i][49:48])
                2'd0:    bus_check(tag, VEC[i][43:32], VEC[i][31:0]);
                2'd1:    bus_write(VEC[i][43:32], VEC[i][31:0]);
                default: one_tick();
            endcase
        end

        // R7: the interrupt output follows raw AND mask (mask=1, raw=0 now)
        @(negedge clk); check("R7 irq low", {31'b0, alarm_irq}, 32'h0);
        bus_write(12'h004, 32'h77);                 // count is 0x77 -> set
        @(negedge clk); check("R7 irq high", {31'b0, alarm_irq}, 32'h1);
        bus_write(12'h010, 32'h0);
        @(negedge clk); check("R7 irq masked", {31'b0, alarm_irq}, 32'h0);
        bus_write(12'h010, 32'h1);
        @(negedge clk); check("R7 irq unmasked", {31'b0, alarm_irq}, 32'h1);

        // R4: load write and tick in one cycle
        @(negedge clk);
        sec_tick = 1'b1; bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 12'h008; bus_wdata = 32'h200;
        @(negedge clk);
        sec_tick = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0;
        bus_check("R4 load wins", 12'h000, 32'h200);

        // R8: set beats clear in the same cycle
        bus_write(12'h008, 32'h300);
        bus_write(12'h004, 32'h301);
        bus_write(12'h01C, 32'h1);
        bus_check("R8 pre-clear", 12'h014, 32'h0);
        @(negedge clk);
        sec_tick = 1'b1; bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 12'h01C; bus_wdata = 32'h1;
        @(negedge clk);
        sec_tick = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0;
        bus_check("R8 set over clear", 12'h014, 32'h1);

        // R3: count holds without ticks
        repeat (5) @(negedge clk);
        bus_check("R3 hold", 12'h000, 32'h301);

        // R1: reset mid-run
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        bus_check("R1 count", 12'h000, 32'h0);
        bus_check("R1 match", 12'h004, 32'h0);
        bus_check("R1 load", 12'h008, 32'h0);
        bus_check("R1 mask", 12'h010, 32'h0);
        bus_check("R1 raw", 12'h014, 32'h0);
        check("R1 irq", {31'b0, alarm_irq}, 32'h0);
        rst_n = 1'b1;

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog (all requirements) actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule